// File: doc/BRIEF.md
# DAC Sample Clock Generator

This block produces the sample-and-hold clock for a DAC converter. A programmable divider turns the module clock into a base tick. Every sample clock period is built from whole base periods: a high portion of 2 or 4 base periods, followed by a low portion of 1 to 4 base periods. A period is either active, where the output pulses, or inactive, where the output stays low for the same length.

After enable, a setup phase issues a programmed number of active periods back to back, so the held value settles quickly. A hold phase then follows and repeats without end. Each active period in the hold phase comes after a programmed run of inactive periods, which refreshes the held value at a low rate.

All configuration is captured at the moment of enable. When enable is cleared, the current period still runs to its end. The output then parks low and both phase status bits read zero.

Top module: `dac_smpclk_gen`

## Requirements
- R1: The base period lasts `clk_div_i + 1` module clock cycles (`clk_div_i` is 6 bits, so division by 1 to 64). The output changes level only at base period boundaries.
- R2: Every active period starts high. It stays high for 2 base periods when `high_sel_i` is 0 and for 4 base periods when `high_sel_i` is 1.
- R3: The low portion of every period lasts `low_sel_i + 1` base periods (1 to 4).
- R4: The setup phase issues exactly `setup_cnt_i + 1` consecutive active periods (1 to 16). During it `setup_busy_o` is 1 and `hold_busy_o` is 0.
- R5: After setup, `hold_busy_o` is 1 and `setup_busy_o` is 0. Each active period is preceded by `hold_gap_i` (0 to 255) inactive periods. An inactive period lasts as long as an active one, with the output low throughout. The pattern repeats until the block is disabled.
- R6: When `en_i` goes low, the period in progress completes unchanged. From the cycle after its last cycle, `smp_clk_o`, `setup_busy_o` and `hold_busy_o` are all 0.
- R7: Raising `en_i` again while a stop is pending does not cancel the stop. The block spends at least one cycle with both status bits at 0, then restarts from the beginning of setup.
- R8: The two status bits are never 1 together. After reset, all outputs are 0.
- R9: The sample taken in the first cycle after the clock edge that sees `en_i` high in idle shows `smp_clk_o` = 1 and `setup_busy_o` = 1. The divider and period counters start from zero.
- R10: The configuration inputs are captured at enable. Changes to them while the block is running have no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sample clock enable |
| clk_div_i | input | 6 | Base tick divider minus one |
| high_sel_i | input | 1 | High time select: 0 gives 2 base periods, 1 gives 4 |
| low_sel_i | input | 2 | Low time minus one, in base periods |
| setup_cnt_i | input | 4 | Setup active periods minus one |
| hold_gap_i | input | 8 | Inactive periods between hold active periods |
| smp_clk_o | output | 1 | Sample clock to the DAC |
| setup_busy_o | output | 1 | Setup phase in progress |
| hold_busy_o | output | 1 | Hold phase in progress |

## Verification
A wrong divider or period counter moves an edge of `smp_clk_o` within the first period, so the fault shows in the first few dozen cycles. A wrong setup or gap count shows as an extra or missing pulse, or as a status transition in the wrong cycle, at the end of setup or in the first hold refresh. A fault in the stop logic shows as a truncated last period or as late status clearing, in the cycle right after the last period boundary. The bench therefore compares all three outputs every cycle against a closed-form waveform model, through enable, the full run and the drain.

// File: rtl/dac_smpclk_pkg.sv
package dac_smpclk_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;

  localparam int unsigned HIGH_SHORT = 2;
  localparam int unsigned HIGH_LONG  = 4;

endpackage

// File: rtl/dac_smpclk_tick_div.sv
// Base tick divider; held at zero while idle so a start is phase-aligned.
module dac_smpclk_tick_div #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == div_i)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == div_i);

endmodule

// File: rtl/dac_smpclk_period.sv
// Position within one sample clock period, in base periods.
module dac_smpclk_period
  import dac_smpclk_pkg::*;
#(
  parameter int unsigned LOW_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             high_sel_i,
  input  logic [LOW_W-1:0] low_sel_i,
  output logic             high_o,
  output logic             period_end_o
);

  localparam int unsigned MAX_LEN = HIGH_LONG + (1 << LOW_W);
  localparam int unsigned POS_W   = $clog2(MAX_LEN);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] high_len;
  logic [POS_W-1:0] last_pos;
  logic             at_last;

  assign high_len = high_sel_i ? POS_W'(HIGH_LONG) : POS_W'(HIGH_SHORT);
  assign last_pos = high_len + POS_W'(low_sel_i);
  assign at_last  = (pos_q == last_pos);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (!run_i)  pos_q <= '0;
    else if (tick_i)  pos_q <= at_last ? '0 : pos_q + 1'b1;
  end

  assign high_o       = (pos_q < high_len);
  assign period_end_o = tick_i && at_last;

endmodule

// File: rtl/dac_smpclk_phase_ctl.sv
// Setup / hold sequencing and graceful stop at a period boundary.
module dac_smpclk_phase_ctl
  import dac_smpclk_pkg::*;
#(
  parameter int unsigned SETUP_W = 4,
  parameter int unsigned GAP_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               period_end_i,
  input  logic [SETUP_W-1:0] setup_cnt_i,
  input  logic [GAP_W-1:0]   hold_gap_i,
  output phase_e             phase_o,
  output logic               active_o
);

  phase_e             phase_q;
  logic [SETUP_W-1:0] set_cnt_q;
  logic [GAP_W-1:0]   gap_cnt_q;
  logic               stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      set_cnt_q <= '0;
      gap_cnt_q <= '0;
      stop_q    <= 1'b0;
    end else if (phase_q == PH_IDLE) begin
      stop_q    <= 1'b0;
      set_cnt_q <= '0;
      gap_cnt_q <= '0;
      if (en_i) phase_q <= PH_SETUP;
    end else begin
      if (!en_i) stop_q <= 1'b1;
      if (period_end_i) begin
        if (stop_q || !en_i) begin
          phase_q <= PH_IDLE;
        end else if (phase_q == PH_SETUP) begin
          if (set_cnt_q == setup_cnt_i) begin
            phase_q   <= PH_HOLD;
            gap_cnt_q <= '0;
          end else begin
            set_cnt_q <= set_cnt_q + 1'b1;
          end
        end else begin
          gap_cnt_q <= (gap_cnt_q == hold_gap_i) ? '0 : gap_cnt_q + 1'b1;
        end
      end
    end
  end

  assign phase_o  = phase_q;
  assign active_o = (phase_q == PH_SETUP) ||
                    ((phase_q == PH_HOLD) && (gap_cnt_q == hold_gap_i));

endmodule

// File: rtl/dac_smpclk_gen.sv
module dac_smpclk_gen
  import dac_smpclk_pkg::*;
#(
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned LOW_W   = 2,
  parameter int unsigned SETUP_W = 4,
  parameter int unsigned GAP_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [DIV_W-1:0]   clk_div_i,
  input  logic               high_sel_i,
  input  logic [LOW_W-1:0]   low_sel_i,
  input  logic [SETUP_W-1:0] setup_cnt_i,
  input  logic [GAP_W-1:0]   hold_gap_i,
  output logic               smp_clk_o,
  output logic               setup_busy_o,
  output logic               hold_busy_o
);

  phase_e             phase;
  logic               run;
  logic               start;
  logic               tick;
  logic               high;
  logic               period_end;
  logic               active;

  logic [DIV_W-1:0]   div_q;
  logic               high_sel_q;
  logic [LOW_W-1:0]   low_sel_q;
  logic [SETUP_W-1:0] setup_q;
  logic [GAP_W-1:0]   gap_q;

  assign run   = (phase != PH_IDLE);
  assign start = (phase == PH_IDLE) && en_i;

  // configuration is frozen for the whole run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q      <= '0;
      high_sel_q <= 1'b0;
      low_sel_q  <= '0;
      setup_q    <= '0;
      gap_q      <= '0;
    end else if (start) begin
      div_q      <= clk_div_i;
      high_sel_q <= high_sel_i;
      low_sel_q  <= low_sel_i;
      setup_q    <= setup_cnt_i;
      gap_q      <= hold_gap_i;
    end
  end

  dac_smpclk_tick_div #(.DIV_W(DIV_W)) i_tick_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  dac_smpclk_period #(.LOW_W(LOW_W)) i_period (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .tick_i       (tick),
    .high_sel_i   (high_sel_q),
    .low_sel_i    (low_sel_q),
    .high_o       (high),
    .period_end_o (period_end)
  );

  dac_smpclk_phase_ctl #(.SETUP_W(SETUP_W), .GAP_W(GAP_W)) i_phase_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .period_end_i (period_end),
    .setup_cnt_i  (setup_q),
    .hold_gap_i   (gap_q),
    .phase_o      (phase),
    .active_o     (active)
  );

  assign smp_clk_o    = run && active && high;
  assign setup_busy_o = (phase == PH_SETUP);
  assign hold_busy_o  = (phase == PH_HOLD);

endmodule

// File: rtl/dac_smpclk_chk.sv
module dac_smpclk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic smp_clk_o,
  input logic setup_busy_o,
  input logic hold_busy_o,
  input logic tick,
  input logic run
);

  a_r8_status_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({setup_busy_o, hold_busy_o}));

  a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!setup_busy_o && !hold_busy_o) |-> !smp_clk_o);

  a_r1_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run) && run && !$past(tick)) |-> $stable(smp_clk_o));

  a_r6_stop_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run) |-> $past(tick));

  a_r5_hold_after_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_busy_o) |-> $past(setup_busy_o));

  a_r9_start_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(setup_busy_o) |-> smp_clk_o);

endmodule

bind dac_smpclk_gen dac_smpclk_chk i_dac_smpclk_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smp_clk_o    (smp_clk_o),
  .setup_busy_o (setup_busy_o),
  .hold_busy_o  (hold_busy_o),
  .tick         (tick),
  .run          (run)
);

// File: tb/test_dac_smpclk_gen.sv
`timescale 1ns/1ps
module test_dac_smpclk_gen;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [5:0] clk_div_i = '0;
  logic       high_sel_i = 1'b0;
  logic [1:0] low_sel_i = '0;
  logic [3:0] setup_cnt_i = '0;
  logic [7:0] hold_gap_i = '0;
  logic       smp_clk_o, setup_busy_o, hold_busy_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  dac_smpclk_gen i_dac_smpclk_gen (
    .clk_i, .rst_ni, .en_i, .clk_div_i, .high_sel_i, .low_sel_i,
    .setup_cnt_i, .hold_gap_i, .smp_clk_o, .setup_busy_o, .hold_busy_o
  );

  // closed-form waveform: {clk, setup, hold} at sample t after the start edge
  function automatic logic [2:0] exp_at(int t, int d, int h, int l, int s, int g);
    int dd = d + 1;
    int hh = h ? 4 : 2;
    int ll = l + 1;
    int pp = (hh + ll) * dd;
    int p  = t / pp;
    int w  = t % pp;
    logic act;
    if (p <= s) return {w < hh * dd, 1'b1, 1'b0};
    act = (((p - s - 1) % (g + 1)) == g);
    return {act && (w < hh * dd), 1'b0, 1'b1};
  endfunction

  function automatic int per_len(int d, int h, int l);
    return ((h ? 4 : 2) + l + 1) * (d + 1);
  endfunction

  task automatic check3(logic [2:0] exp, string tag);
    logic [2:0] act = {smp_clk_o, setup_busy_o, hold_busy_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {clk,setup,hold} actual %b expected %b at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp(int t, int d, int h, int l, int s, int g, string tag);
    string tg = tag;
    if (tg == "") begin
      int pp = per_len(d, h, l);
      if (t == 0) tg = "R9";
      else if (t / pp <= s) tg = ((t % pp) < (h ? 4 : 2) * (d + 1)) ? "R4 R2 R1" : "R4 R3 R1";
      else tg = "R5";
    end
    check3(exp_at(t, d, h, l, s, g), tg);
  endtask

  task automatic start(int d, int h, int l, int s, int g);
    @(negedge clk_i);
    clk_div_i = 6'(d); high_sel_i = 1'(h); low_sel_i = 2'(l);
    setup_cnt_i = 4'(s); hold_gap_i = 8'(g);
    en_i = 1'b1;
    @(posedge clk_i);
  endtask

  // en_i dropped after sample 'last'; finish the period then expect idle
  task automatic drain(int last, int d, int h, int l, int s, int g, string tag);
    int pp = per_len(d, h, l);
    int endt = (last / pp + 1) * pp;
    for (int t = last + 1; t < endt; t++) begin
      @(negedge clk_i);
      cmp(t, d, h, l, s, g, tag);
    end
    @(negedge clk_i); check3(3'b000, tag);
    @(negedge clk_i); check3(3'b000, tag);
  endtask

  task automatic run_case(int d, int h, int l, int s, int g, int n, bit scramble);
    start(d, h, l, s, g);
    for (int t = 0; t < n; t++) begin
      @(negedge clk_i);
      cmp(t, d, h, l, s, g, scramble && t > 0 ? "R10" : "");
      if (scramble && t == 0) begin
        clk_div_i = ~clk_div_i; high_sel_i = ~high_sel_i; low_sel_i = ~low_sel_i;
        setup_cnt_i = ~setup_cnt_i; hold_gap_i = ~hold_gap_i;
      end
    end
    en_i = 1'b0;
    drain(n - 1, d, h, l, s, g, "R6");
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    check3(3'b000, "R8");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check3(3'b000, "R8");
  endtask

  task automatic test_reenable();
    int d = 1, h = 0, l = 1, s = 1, g = 2;
    int pp = per_len(d, h, l);   // 8
    int n = pp + 2;              // drop early in second period
    int endt = 2 * pp;
    start(d, h, l, s, g);
    for (int t = 0; t < n; t++) begin
      @(negedge clk_i);
      cmp(t, d, h, l, s, g, "");
    end
    en_i = 1'b0;
    @(negedge clk_i);
    cmp(n, d, h, l, s, g, "R7");
    en_i = 1'b1;
    for (int t = n + 1; t < endt; t++) begin
      @(negedge clk_i);
      cmp(t, d, h, l, s, g, "R7");
    end
    @(negedge clk_i); check3(3'b000, "R7");
    for (int t = 0; t < 3 * pp; t++) begin
      @(negedge clk_i);
      cmp(t, d, h, l, s, g, "R7");
    end
    en_i = 1'b0;
    drain(3 * pp - 1, d, h, l, s, g, "R6");
  endtask

  initial begin
    test_reset();
    run_case(0, 0, 0, 0, 0, 60, 1'b0);      // fastest, continuous hold
    run_case(2, 1, 3, 2, 3, 500, 1'b0);     // R1 R2 R3 mixed timing
    run_case(1, 0, 2, 3, 1, 240, 1'b1);     // R10 config change ignored
    run_case(0, 0, 0, 0, 255, 1600, 1'b0);  // R5 longest gap
    run_case(63, 1, 3, 15, 1, 9500, 1'b0);  // R1 R4 largest divider and setup
    run_case(3, 1, 0, 0, 0, 45, 1'b0);      // R6 stop mid high portion
    test_reenable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

endmodule